// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the flash read path and decides what byte reaches the data bus. While the flash array is idle it passes the addressed array byte through unchanged. While an internal program or erase runs, it substitutes a status byte. The top bit is a polarity flag that tells software the operation is still running. The next bit flips on every new read. The low bits carry a fixed filler value. When the operation ends, a settle window of a parameterised number of clock cycles follows. During that window only the top bit is already trustworthy.

A separate controller raises `busy` once the final write of a command sequence is accepted. For a program that is the fourth write; for an erase it is the sixth. In the same cycle the controller presents `op_erase` and the top bit of the byte being written. The block samples both when it leaves the idle or settle state. It holds them until the next operation starts, so later changes on those pins have no effect mid-operation.

States: `ST_IDLE` (pass-through), `ST_PROG` (program status), `ST_ERASE` (erase status) and `ST_SETTLE` (settle window). Transitions:
- IDLE→PROG or IDLE→ERASE when `busy` is high; `op_erase` picks the target.
- PROG→SETTLE and ERASE→SETTLE when `busy` is low.
- SETTLE→PROG or SETTLE→ERASE when `busy` is high again (restart).
- SETTLE→IDLE after `SETTLE_CYC` cycles in the settle state with `busy` low.

Top module: `done_status_rpt`

## Requirements
- R1: After reset the block is in ST_IDLE and `dq_out` equals `array_byte`.
- R2: In ST_IDLE, `dq_out` equals `array_byte` in the same cycle, for any array value.
- R3: In ST_PROG, `dq_out[7]` is the inverse of `wr_msb` as sampled when the program started. Later changes of `wr_msb` do not alter it.
- R4: In ST_ERASE, `dq_out[7]` is 0.
- R5: In ST_PROG and ST_ERASE, `dq_out[6]` is 0 in the first status cycle. It inverts in the cycle after each rising edge of `rd_en`. A held-high `rd_en` causes no further inversion.
- R6: In ST_PROG and ST_ERASE, `dq_out[5:0]` equals `FILL[5:0]`.
- R7: After `busy` falls, the block spends exactly `SETTLE_CYC` cycles in ST_SETTLE. In that window `dq_out[7]` equals `array_byte[7]` and `dq_out[6:0]` equals `FILL`.
- R8: Once the settle window expires, the block returns to ST_IDLE pass-through.
- R9: `op_erase` is sampled only on entry to a status state. Changing it during an operation does not change the reported kind.
- R10: `busy` rising during ST_SETTLE starts a new status period at once, with bit 6 cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | 1 = erase, 0 = program; sampled at operation start |
| wr_msb | input | 1 | Top bit of the byte being programmed; sampled at operation start |
| array_byte | input | 8 | True array byte at the addressed location |
| rd_en | input | 1 | Qualified flash read strobe |
| dq_out | output | 8 | Byte presented to the data bus |

## Verification
The assertions assume `rd_en`, `busy` and the sampled operands are synchronous to `clk` and free of X after reset. They also assume a status period ends only through `busy` falling. The stimulus drives every input on the falling edge. It holds `busy` high for multi-cycle spans and chooses `rd_en` pulses and holds at random, so rising edges, held reads and idle gaps all occur. It also lets `busy` return inside the settle window, which exercises the restart path that the checker watches.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROG   = 2'd1,
        ST_ERASE  = 2'd2,
        ST_SETTLE = 2'd3
    } dsr_state_e;
endpackage

// File: rtl/dsr_rise_det.sv
module dsr_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/dsr_toggle.sv
module dsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic tog
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   tog <= 1'b0;
        else if (clr) tog <= 1'b0;
        else if (adv) tog <= ~tog;
    end
endmodule

// File: rtl/dsr_settle_cnt.sv
module dsr_settle_cnt #(
    parameter int CYC = 8,
    localparam int CW = (CYC < 2) ? 1 : $clog2(CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else if (!last) cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == CW'(CYC - 1));
endmodule

// File: rtl/done_status_rpt.sv
module done_status_rpt #(
    parameter int          DW         = 8,
    parameter int          SETTLE_CYC = 8,
    parameter logic [DW-2:0] FILL     = 7'h2A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          op_erase,
    input  logic          wr_msb,
    input  logic [DW-1:0] array_byte,
    input  logic          rd_en,
    output logic [DW-1:0] dq_out
);
    import dsr_pkg::*;

    localparam int POLL_B = DW - 1;
    localparam int TOG_B  = DW - 2;

    dsr_state_e st_q, st_d;
    logic       start;
    logic       msb_q;
    logic       rd_rise;
    logic       tog;
    logic       settle_last;
    logic       in_op;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (busy) begin
                    start = 1'b1;
                    st_d  = op_erase ? ST_ERASE : ST_PROG;
                end
            end
            ST_PROG, ST_ERASE: begin
                if (!busy) st_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (busy) begin
                    start = 1'b1;
                    st_d  = op_erase ? ST_ERASE : ST_PROG;
                end else if (settle_last) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // operand capture at operation start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     msb_q <= 1'b0;
        else if (start) msb_q <= wr_msb;
    end

    assign in_op = (st_q == ST_PROG) || (st_q == ST_ERASE);

    dsr_rise_det u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (rd_en),
        .rise (rd_rise)
    );

    dsr_toggle u_tog (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .adv  (rd_rise & in_op),
        .tog  (tog)
    );

    dsr_settle_cnt #(.CYC(SETTLE_CYC)) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q == ST_SETTLE),
        .last (settle_last)
    );

    // output mux
    always_comb begin
        dq_out = array_byte;
        unique case (st_q)
            ST_IDLE: dq_out = array_byte;
            ST_PROG: begin
                dq_out[POLL_B]    = ~msb_q;
                dq_out[TOG_B]     = tog;
                dq_out[TOG_B-1:0] = FILL[TOG_B-1:0];
            end
            ST_ERASE: begin
                dq_out[POLL_B]    = 1'b0;
                dq_out[TOG_B]     = tog;
                dq_out[TOG_B-1:0] = FILL[TOG_B-1:0];
            end
            ST_SETTLE: begin
                dq_out[POLL_B]  = array_byte[POLL_B];
                dq_out[TOG_B:0] = FILL;
            end
            default: dq_out = array_byte;
        endcase
    end
endmodule

// File: rtl/dsr_chk.sv
module dsr_chk #(
    parameter int          DW         = 8,
    parameter int          SETTLE_CYC = 8,
    parameter logic [DW-2:0] FILL     = 7'h2A,
    localparam int CW = $clog2(SETTLE_CYC + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rd_en,
    input logic [DW-1:0] array_byte,
    input logic [DW-1:0] dq_out,
    input logic [1:0]    st
);
    localparam logic [1:0] S_IDLE = 2'd0, S_PROG = 2'd1, S_ERASE = 2'd2, S_SETTLE = 2'd3;

    logic          rd_d;
    logic [CW-1:0] run_c;
    logic          op_now;

    assign op_now = (st == S_PROG) || (st == S_ERASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_d  <= 1'b0;
            run_c <= '0;
        end else begin
            rd_d  <= rd_en;
            run_c <= (st == S_SETTLE && !busy) ? run_c + 1'b1 : '0;
        end
    end

    // R2
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_IDLE |-> dq_out == array_byte);

    // R3
    prog_poll_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PROG && $past(st) == S_PROG) |-> $stable(dq_out[DW-1]));

    // R4
    erase_poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_ERASE |-> !dq_out[DW-1]);

    // R5
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_now && $past(op_now) && $past(rd_en) && !$past(rd_d))
        |-> dq_out[DW-2] != $past(dq_out[DW-2]));

    // R5
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_now && $past(op_now) && !($past(rd_en) && !$past(rd_d)))
        |-> $stable(dq_out[DW-2]));

    // R6
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_now |-> dq_out[DW-3:0] == FILL[DW-3:0]);

    // R7
    settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_SETTLE |-> run_c < CW'(SETTLE_CYC));

    // R8
    settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SETTLE && !busy && run_c == CW'(SETTLE_CYC - 1)) |=> st == S_IDLE);

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SETTLE && busy) |=> (op_now && !dq_out[DW-2]));
endmodule

bind done_status_rpt dsr_chk #(.DW(DW), .SETTLE_CYC(SETTLE_CYC), .FILL(FILL)) u_dsr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rd_en     (rd_en),
    .array_byte(array_byte),
    .dq_out    (dq_out),
    .st        (st_q)
);

// File: tb/tb_done_status_rpt.sv
`timescale 1ns/1ps
module tb_done_status_rpt;
    localparam int          S    = 8;
    localparam logic [6:0]  FILL = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0, op_erase = 1'b0, wr_msb = 1'b0, rd_en = 1'b0;
    logic [7:0] array_byte = 8'h5C;
    logic [7:0] dq_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state: 0 idle, 1 prog, 2 erase, 3 settle
    int   m_mode = 0, m_cnt = 0;
    logic m_tog = 0, m_b7 = 0, m_rdq = 0;

    always #2.5 clk = ~clk;

    done_status_rpt #(.DW(8), .SETTLE_CYC(S), .FILL(FILL)) dut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
        .wr_msb(wr_msb), .array_byte(array_byte), .rd_en(rd_en), .dq_out(dq_out)
    );

    function automatic logic [7:0] exp_val();
        case (m_mode)
            1:       return {~m_b7, m_tog, FILL[5:0]};
            2:       return {1'b0, m_tog, FILL[5:0]};
            3:       return {array_byte[7], FILL};
            default: return array_byte;
        endcase
    endfunction

    function automatic string mode_tag();
        case (m_mode)
            1: return "R3";
            2: return "R4";
            3: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic model_step();
        logic rise;
        rise  = rd_en & ~m_rdq;
        m_rdq = rd_en;
        if (m_mode == 0 || m_mode == 3) begin
            if (busy) begin
                m_mode = op_erase ? 2 : 1;
                m_b7 = wr_msb; m_tog = 0; m_cnt = 0;
            end else if (m_mode == 3) begin
                if (m_cnt == S - 1) m_mode = 0;
                else m_cnt++;
            end
        end else begin
            if (rise) m_tog = ~m_tog;
            if (!busy) begin m_mode = 3; m_cnt = 0; end
        end
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // apply inputs at negedge, clock once, check at next negedge
    task automatic cyc(input logic b, input logic e, input logic m, input logic [7:0] a,
                       input logic r, input string tag);
        busy = b; op_erase = e; wr_msb = m; array_byte = a; rd_en = r;
        @(posedge clk); #1;
        model_step();
        @(negedge clk);
        check(tag == "" ? mode_tag() : tag, dq_out, exp_val());
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        check("R1", dq_out, 8'h5C);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", dq_out, 8'h5C);

        // R2 idle pass-through with several array values
        cyc(0, 0, 0, 8'hA5, 0, "R2");
        cyc(0, 0, 0, 8'h00, 1, "R2");
        cyc(0, 0, 0, 8'hFF, 0, "R2");

        // program with written msb 1
        cyc(1, 0, 1, 8'h11, 0, "R3");
        check("R5", {7'd0, dq_out[6]}, 8'h00);
        cyc(1, 1, 0, 8'h22, 0, "R9");   // op_erase and wr_msb change mid-op
        check("R3", {7'd0, dq_out[7]}, 8'h00);
        cyc(1, 1, 0, 8'h22, 1, "R5");
        check("R5", {7'd0, dq_out[6]}, 8'h01);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 8'h33, 1, "R5");
        check("R5", {7'd0, dq_out[6]}, 8'h01);
        cyc(1, 0, 0, 8'h33, 0, "R6");
        check("R6", {2'd0, dq_out[5:0]}, {2'd0, FILL[5:0]});
        cyc(1, 0, 0, 8'h33, 1, "R5");
        check("R5", {7'd0, dq_out[6]}, 8'h00);

        // end of program, settle window
        for (int i = 0; i < S; i++) cyc(0, 0, 0, (i % 2) ? 8'h80 : 8'h7F, i[0], "R7");
        cyc(0, 0, 0, 8'h96, 0, "R8");
        check("R8", dq_out, 8'h96);

        // erase, then restart during settle
        cyc(1, 1, 0, 8'h44, 0, "R4");
        cyc(1, 0, 1, 8'h44, 1, "R4");
        cyc(0, 0, 0, 8'hFF, 0, "R7");
        cyc(0, 0, 0, 8'hFF, 0, "R7");
        cyc(1, 0, 0, 8'hFF, 0, "R10");
        check("R10", {7'd0, dq_out[6]}, 8'h00);
        check("R10", {7'd0, dq_out[7]}, 8'h01);
        cyc(0, 0, 0, 8'h01, 0, "R7");
        for (int i = 0; i < S + 2; i++) cyc(0, 0, 0, 8'h3C, 0, "");

        // constrained random phase
        begin
            logic b = 0;
            for (int i = 0; i < 3000; i++) begin
                if ($urandom_range(0, 19) == 0) b = ~b;
                cyc(b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    8'($urandom_range(0, 255)), ($urandom_range(0, 2) != 0), "");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule